// File: doc/BRIEF.md
# Multiplexed Address Capture and Bus-Direction Controller

This block is the memory-side front end of a device with a 16-bit shared address/data bus. An access sends its address in up to two slots on that bus: an upper half and then a lower half. The block classifies each strobe combination as an upper-half capture, a lower-half capture, or nothing. It latches the halves into a full word address and keeps the last upper half, so an access that stays in the same 128-KByte window only has to send the lower half.

The block also controls bus direction. It turns the bus to output only for a read that has had its lower half captured. It returns the bus to input when chip enable rises, or when output enable rises after ready has been seen. It keeps the bus as input throughout a write.

Two capture styles are supported. In the edge style (the default after reset), the strobes are sampled on the system clock and a captured rising edge of the address-valid strobe latches the bus. In the clocked style, every clock edge that sees the address-valid strobe low latches the bus.

Top module: `adq_capture_ctrl`

## Requirements
- R1: In edge mode, with `ce_n` low, a clock edge that sees `avd_n` high after it was low at the previous edge, and `oe_n` low, loads `adq_in` into the upper half. The upper half is bits 31:16 of `word_addr`, visible after that edge.
- R2: In edge mode, the same `avd_n` low-to-high transition with `oe_n` high loads `adq_in` into the lower half. The lower half is bits 15:0 of `word_addr`. This also starts an access, and `acc_active` reads 1 after that edge.
- R3: In clocked mode, every clock edge with `ce_n` low and `avd_n` low captures `adq_in`. It goes to the upper half when `oe_n` is low and to the lower half when `oe_n` is high.
- R4: An access that captures only a lower half keeps the previously captured upper half in `word_addr[31:16]`.
- R5: A clock edge with `rst` high sets the upper half to all zeros when `boot_top` is 0, or to all ones when it is 1. It clears the lower half, and `bus_oe` and `acc_active` read 0 afterwards.
- R6: After reset the block is in edge mode. A clock edge with `mode_wr` high selects clocked mode if `mode_sync` is 1 and edge mode if it is 0. In edge mode, `avd_n` held low at a clock edge captures nothing.
- R7: An upper-half capture never makes `bus_oe` high, even with `oe_n` low, until a later lower-half capture.
- R8: After a lower-half capture with `we_n` high, `bus_oe` is 1 whenever `ce_n` is low, `oe_n` is low and `we_n` is high.
- R9: `ce_n` high forces `bus_oe` to 0 at once and ends the access. `acc_active` reads 0 after the next edge. The bus stays as input after `ce_n` returns low, until a new lower-half capture.
- R10: `oe_n` high before `rdy` has been seen only pauses driving. `oe_n` high at an edge after an edge that saw `rdy` high ends the read. A later `oe_n` low is then ignored until the next lower-half capture.
- R11: `we_n` low during an access turns it into a write. `bus_oe` stays 0 for the rest of that access, even if `we_n` returns high with `oe_n` low.
- R12: While `rst` is high, `bus_oe` is 0 whatever the strobes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| boot_top | input | 1 | Boot strap: 1 presets upper half to all ones |
| mode_wr | input | 1 | Load strobe for the capture-mode select |
| mode_sync | input | 1 | Mode value: 1 clocked, 0 edge |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| rdy | input | 1 | Ready indication from the timing generator |
| adq_in | input | 16 | Bus value seen as input |
| word_addr | output | 32 | Upper half concatenated above lower half |
| bus_oe | output | 1 | Bus drives read data when 1 |
| acc_active | output | 1 | A lower-half-started access is in progress |

## Verification
The bench targets several corner cases, each with the symptom a faulty design would show:
- Output enable held low during an upper-half capture: a design that turned the bus on there would show `bus_oe` high with no lower half yet, which is a bus conflict.
- Output enable toggled before and after ready: a design that ended the read on the first rise would never drive again, while one that ignored the rule would drive again after termination.
- A write whose write strobe returns high: a faulty design would drive the bus while the host still owns it.
- Reset under both boot straps, plus a level-held address-valid strobe in edge mode: these catch a wrong preset window and a design that captures on the level rather than the edge.

// File: rtl/adq_pkg.sv
package adq_pkg;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_HI   = 2'd1,
        CAP_LO   = 2'd2
    } cap_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HI    = 3'd1,
        S_READ  = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } dir_st_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic avd_n;
    } strobe_t;

    // Classify the strobes seen at one clock edge.
    function automatic cap_e classify(input logic sync_mode,
                                      input strobe_t s,
                                      input logic avd_prev);
        cap_e c;
        c = CAP_NONE;
        if (!s.ce_n) begin
            if (sync_mode) begin
                if (!s.avd_n) c = s.oe_n ? CAP_LO : CAP_HI;
            end else begin
                if (s.avd_n && !avd_prev) c = s.oe_n ? CAP_LO : CAP_HI;
            end
        end
        return c;
    endfunction

    function automatic logic is_live(input dir_st_e st);
        return (st == S_READ) || (st == S_WRITE);
    endfunction

endpackage

// File: rtl/adq_strobe_decode.sv
module adq_strobe_decode
    import adq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    mode_wr,
    input  logic    mode_sync,
    input  strobe_t strb,
    output cap_e    cap,
    output logic    sync_q
);

    logic avd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            avd_q  <= 1'b1;
            sync_q <= 1'b0;
        end else begin
            avd_q <= strb.avd_n;
            if (mode_wr) sync_q <= mode_sync;
        end
    end

    always_comb begin
        cap = classify(sync_q, strb, avd_q);
    end

    // R6: in edge mode a low level of the strobe alone never captures
    p_async_level_r6: assert property (@(posedge clk) disable iff (rst)
        (!sync_q && !strb.avd_n) |-> (cap == CAP_NONE));

endmodule

// File: rtl/adq_addr_latch.sv
module adq_addr_latch
    import adq_pkg::*;
#(
    parameter int HI_W = 16,
    parameter int LO_W = 16,
    localparam int AW = HI_W + LO_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boot_top,
    input  cap_e            cap,
    input  logic [LO_W-1:0] bus_in,
    output logic [AW-1:0]   word_addr
);

    logic [HI_W-1:0] upper_q;
    logic [LO_W-1:0] lower_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= {HI_W{boot_top}};
            lower_q <= '0;
        end else begin
            if (cap == CAP_HI) upper_q <= bus_in[HI_W-1:0];
            if (cap == CAP_LO) lower_q <= bus_in;
        end
    end

    assign word_addr = {upper_q, lower_q};

    // R5: reset presets the window by the strap
    p_upper_reset_r5: assert property (@(posedge clk)
        $past(rst) |-> (upper_q == {HI_W{$past(boot_top)}}));

    // R4: upper half is kept unless an upper capture happens
    p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cap != CAP_HI) |=> $stable(upper_q));

    // R2: lower capture takes the bus value
    p_lower_take_r2: assert property (@(posedge clk) disable iff (rst)
        (cap == CAP_LO) |=> (lower_q == $past(bus_in)));

endmodule

// File: rtl/adq_dir_ctrl.sv
module adq_dir_ctrl
    import adq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cap_e    cap,
    input  strobe_t strb,
    input  logic    rdy,
    output logic    bus_oe,
    output logic    acc_active
);

    dir_st_e st_q, st_d;
    logic    rdy_seen_q, rdy_seen_d;

    always_comb begin
        st_d       = st_q;
        rdy_seen_d = rdy_seen_q;
        if (cap == CAP_LO) begin
            st_d       = strb.we_n ? S_READ : S_WRITE;
            rdy_seen_d = 1'b0;
        end else if (cap == CAP_HI) begin
            st_d       = S_HI;
            rdy_seen_d = 1'b0;
        end else if (strb.ce_n) begin
            st_d       = S_IDLE;
            rdy_seen_d = 1'b0;
        end else begin
            unique case (st_q)
                S_READ: begin
                    if (!strb.we_n)                    st_d = S_WRITE;
                    else if (strb.oe_n && rdy_seen_q)  st_d = S_DONE;
                    if (rdy) rdy_seen_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            rdy_seen_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            rdy_seen_q <= rdy_seen_d;
        end
    end

    assign bus_oe     = !rst && (st_q == S_READ) && !strb.ce_n
                        && !strb.oe_n && strb.we_n;
    assign acc_active = is_live(st_q);

    // R7: an upper capture never turns the bus around
    p_hi_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        (cap == CAP_HI) |=> !bus_oe);

    // R9: chip deselect ends the access
    p_ce_ends_r9: assert property (@(posedge clk) disable iff (rst)
        strb.ce_n |=> !acc_active);

    // R11: a write strobe leaves the bus as input afterwards
    p_write_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!strb.we_n && !strb.ce_n && cap == CAP_NONE) |=> !bus_oe);

endmodule

// File: rtl/adq_capture_ctrl.sv
module adq_capture_ctrl
    import adq_pkg::*;
#(
    parameter int HI_W = 16,
    parameter int LO_W = 16,
    localparam int AW = HI_W + LO_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boot_top,
    input  logic            mode_wr,
    input  logic            mode_sync,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            avd_n,
    input  logic            rdy,
    input  logic [LO_W-1:0] adq_in,
    output logic [AW-1:0]   word_addr,
    output logic            bus_oe,
    output logic            acc_active
);

    strobe_t strb;
    cap_e    cap;
    logic    sync_q;

    assign strb = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, avd_n: avd_n};

    adq_strobe_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_sync(mode_sync),
        .strb     (strb),
        .cap      (cap),
        .sync_q   (sync_q)
    );

    adq_addr_latch #(.HI_W(HI_W), .LO_W(LO_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .boot_top (boot_top),
        .cap      (cap),
        .bus_in   (adq_in),
        .word_addr(word_addr)
    );

    adq_dir_ctrl u_dir (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .strb      (strb),
        .rdy       (rdy),
        .bus_oe    (bus_oe),
        .acc_active(acc_active)
    );

    // R8: driving implies a live access
    p_drive_live_r8: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> acc_active);

    // R12: no driving in reset
    always_comb begin
        if (rst) p_rst_hiz_r12: assert (!bus_oe);
    end

endmodule

// File: tb/adq_capture_ctrl_tb.sv
`timescale 1ns/100ps
module adq_capture_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_top = 1'b0;
    logic        mode_wr = 1'b0;
    logic        mode_sync = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, avd_n = 1'b1, rdy = 1'b0;
    logic [15:0] adq_in = '0;
    logic [31:0] word_addr;
    logic        bus_oe, acc_active;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    adq_capture_ctrl u_dut (
        .clk(clk), .rst(rst), .boot_top(boot_top), .mode_wr(mode_wr),
        .mode_sync(mode_sync), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .avd_n(avd_n), .rdy(rdy), .adq_in(adq_in), .word_addr(word_addr),
        .bus_oe(bus_oe), .acc_active(acc_active)
    );

    typedef struct packed {
        logic        ce, oe, we, avd, rd;
        logic [15:0] dat;
        logic        x_oe, x_act;
        logic [31:0] x_addr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1,1,1,1,0,16'h0000, 0,0,32'h0000_0000, 5},  // R5 idle after reset
        '{0,0,1,0,0,16'h0012, 0,0,32'h0000_0000, 7},  // R7 strobe low
        '{0,0,1,1,0,16'h0012, 0,0,32'h0012_0000, 1},  // R1 upper capture
        '{0,1,1,0,0,16'hABCD, 0,0,32'h0012_0000, 7},
        '{0,1,1,1,0,16'hABCD, 0,1,32'h0012_ABCD, 2},  // R2 lower capture
        '{0,0,1,1,0,16'h0000, 1,1,32'h0012_ABCD, 8},  // R8 drive
        '{0,1,1,1,0,16'h0000, 0,1,32'h0012_ABCD, 10}, // R10 pause
        '{0,0,1,1,0,16'h0000, 1,1,32'h0012_ABCD, 10}, // R10 resume
        '{0,0,1,1,1,16'h0000, 1,1,32'h0012_ABCD, 8},
        '{0,1,1,1,0,16'h0000, 0,0,32'h0012_ABCD, 10}, // R10 end
        '{0,0,1,1,0,16'h0000, 0,0,32'h0012_ABCD, 10}, // R10 ignored
        '{0,1,1,0,0,16'h5555, 0,0,32'h0012_ABCD, 4},
        '{0,1,1,1,0,16'h5555, 0,1,32'h0012_5555, 4},  // R4 upper kept
        '{0,0,1,1,0,16'h0000, 1,1,32'h0012_5555, 8},
        '{1,0,1,1,0,16'h0000, 0,0,32'h0012_5555, 9},  // R9 deselect
        '{0,0,1,1,0,16'h0000, 0,0,32'h0012_5555, 9},  // R9 stays ended
        '{0,1,1,0,0,16'h0100, 0,0,32'h0012_5555, 4},
        '{0,1,1,1,0,16'h0100, 0,1,32'h0012_0100, 4},
        '{0,1,0,1,0,16'h0000, 0,1,32'h0012_0100, 11}, // R11 write
        '{0,0,1,1,0,16'h0000, 0,1,32'h0012_0100, 11}, // R11 stays input
        '{1,1,1,1,0,16'h0000, 0,0,32'h0012_0100, 9}
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic w,
                         input logic a, input logic r, input logic [15:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; avd_n = a; rdy = r; adq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic top);
        @(negedge clk);
        rst = 1'b1; boot_top = top;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; avd_n = 1'b1;
        #1;
        chk(12, {31'b0, bus_oe}, 32'd0);   // R12 gated in reset
        @(posedge clk); #1;
        chk(12, {31'b0, bus_oe}, 32'd0);
        @(negedge clk);
        rst = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(5, word_addr, 32'h0000_0000);   // R5 bottom boot
        chk(5, {30'b0, bus_oe, acc_active}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ce, VECS[i].oe, VECS[i].we, VECS[i].avd, VECS[i].rd, VECS[i].dat);
            chk(int'(VECS[i].req), {31'b0, bus_oe}, {31'b0, VECS[i].x_oe});
            chk(int'(VECS[i].req), {31'b0, acc_active}, {31'b0, VECS[i].x_act});
            chk(int'(VECS[i].req), word_addr, VECS[i].x_addr);
        end

        // R5 R12: top boot preset
        do_reset(1'b1);
        #1;
        chk(5, word_addr, 32'hFFFF_0000);

        // R6: edge mode after reset, level does not capture
        drive(0, 1, 1, 0, 0, 16'h7777);
        drive(0, 1, 1, 0, 0, 16'h7777);
        chk(6, word_addr, 32'hFFFF_0000);
        drive(0, 1, 1, 1, 0, 16'h7777);
        chk(6, word_addr, 32'hFFFF_7777);
        drive(1, 1, 1, 1, 0, 16'h0000);

        // R3: clocked mode
        @(negedge clk); mode_wr = 1'b1; mode_sync = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
        drive(0, 0, 1, 0, 0, 16'h0003);
        chk(3, word_addr, 32'h0003_7777);
        chk(7, {31'b0, bus_oe}, 32'd0);     // R7
        drive(0, 1, 1, 0, 0, 16'h1234);
        chk(3, word_addr, 32'h0003_1234);
        chk(3, {31'b0, acc_active}, 32'd1);
        drive(0, 0, 1, 1, 0, 16'h0000);
        chk(8, {31'b0, bus_oe}, 32'd1);     // R8
        drive(1, 1, 1, 1, 0, 16'h0000);
        drive(0, 1, 1, 0, 0, 16'h0042);
        chk(4, word_addr, 32'h0003_0042);   // R4 in clocked mode

        // R6: reset returns to edge mode
        do_reset(1'b0);
        drive(0, 1, 1, 0, 0, 16'h0099);
        chk(6, word_addr, 32'h0000_0000);
        chk(6, {31'b0, acc_active}, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule